// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit with Condition Evaluation

This block adds or subtracts two integer operands on a single shared adder and reports the result together with four status flags: negative, zero, carry and overflow. Subtraction is formed by presenting the bitwise complement of the second operand to the adder with the carry-in forced high. Addition passes both operands straight through with a carry-in of zero. The adder works on bit patterns only. Carry reports unsigned overflow and overflow reports signed overflow, and both are produced on every operation.

The result is registered every cycle. The four flags are captured in a flag register only on cycles where the set-flags input is high, and they hold their value otherwise. A 4-bit condition selector is evaluated without a clock against the stored flags to give one pass/fail bit. Later logic can use that bit to decide whether a dependent operation should take effect.

Top module: `addsub_cond_unit`

## Requirements
- R1: One clock edge after an operation is presented, `result` equals `op_a + op_b` (with `do_sub`=0) or `op_a - op_b` (with `do_sub`=1), modulo 2^DATA_W.
- R2: When flags are captured, `flag_n` equals the most significant bit of the captured result, whatever the signedness of the operands.
- R3: When flags are captured, `flag_z` is 1 exactly when every bit of the captured result is 0.
- R4: When flags are captured, `flag_c` is the carry out of the top adder bit. For an add this means the unsigned sum exceeded 2^DATA_W-1. For a subtract it means no borrow occurred, i.e. `op_a >= op_b` unsigned.
- R5: When flags are captured, `flag_v` is 1 exactly when two's-complement overflow occurred. For an add, the operands share a sign that differs from the result's sign. For a subtract, the operand signs differ and the result's sign differs from `op_a`'s sign.
- R6: The flag outputs change only on a clock edge where `set_flags` is high. With `set_flags` low they hold their value, while `result` still updates.
- R7: A synchronous active-high `rst` clears `result` and all four flags to 0.
- R8: `cond_pass` follows the stored flags under this encoding of `cond_code`:
  - 0000 Z
  - 0001 !Z
  - 0010 C
  - 0011 !C
  - 0100 N
  - 0101 !N
  - 0110 V
  - 0111 !V
  - 1000 C&!Z
  - 1001 !C|Z
  - 1010 N==V
  - 1011 N!=V
  - 1100 !Z&(N==V)
  - 1101 Z|(N!=V)
  - 1110 always 1
  - 1111 always 1
- R9: `cond_pass` depends only on `cond_code` and the stored flags. It follows a change of `cond_code` within the same cycle, without waiting for a clock edge.
- R10: With stored flags N=1, Z=0, C=0, codes 0000, 0010, 0101 and 1000 fail, and codes 0001, 0011, 0100 and 1001 pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| do_sub | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b |
| set_flags | input | 1 | Capture the flags of this operation |
| cond_code | input | 4 | Condition selector |
| result | output | DATA_W | Registered sum or difference |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry / no-borrow flag |
| flag_v | output | 1 | Stored signed-overflow flag |
| cond_pass | output | 1 | Condition outcome from stored flags |

## Verification
The adder is exercised with sums that are zero, that cross the signed boundary 0x7FFFFFFF+1, that wrap to zero from all ones, and that add two minimum negatives. These cases separate the carry flag from the overflow flag and show that negative tracks bit 31 alone. Subtractions cover equal operands, a borrow, the minimum value minus one, and zero minus the minimum value. They confirm that carry means "no borrow" and that the inverted-operand path is in use. A hold sequence runs operations with capture disabled to show that the result moves while the flags stay put. All sixteen condition codes are then swept, without clock edges, over several stored flag patterns, including the negative-without-carry case.

// File: rtl/addsub_cond_pkg.sv
package addsub_cond_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [3:0] {
    COND_EQ = 4'd0,
    COND_NE = 4'd1,
    COND_CS = 4'd2,
    COND_CC = 4'd3,
    COND_MI = 4'd4,
    COND_PL = 4'd5,
    COND_VS = 4'd6,
    COND_VC = 4'd7,
    COND_HI = 4'd8,
    COND_LS = 4'd9,
    COND_GE = 4'd10,
    COND_LT = 4'd11,
    COND_GT = 4'd12,
    COND_LE = 4'd13,
    COND_AL = 4'd14,
    COND_AX = 4'd15
  } cond_e;

endpackage

// File: rtl/addsub_core.sv
module addsub_core
  import addsub_cond_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output flags_t            flags_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    // one shared adder: subtract = add inverted operand plus one
    b_eff = sub_i ? ~b_i : b_i;
    wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
    sum_o = wide[MSB:0];
    flags_o.n = wide[MSB];
    flags_o.z = (wide[MSB:0] == '0);
    flags_o.c = wide[DATA_W];
    flags_o.v = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
  end

endmodule

// File: rtl/flag_store.sv
module flag_store
  import addsub_cond_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);

  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(q_o));

  // R7
  flags_reset_chk: assert property (@(posedge clk)
    rst |=> (q_o == '0));

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import addsub_cond_pkg::*;
(
  input  flags_t     f_i,
  input  logic [3:0] code_i,
  output logic       pass_o
);

  always_comb begin
    case (code_i)
      COND_EQ: pass_o = f_i.z;
      COND_NE: pass_o = !f_i.z;
      COND_CS: pass_o = f_i.c;
      COND_CC: pass_o = !f_i.c;
      COND_MI: pass_o = f_i.n;
      COND_PL: pass_o = !f_i.n;
      COND_VS: pass_o = f_i.v;
      COND_VC: pass_o = !f_i.v;
      COND_HI: pass_o = f_i.c && !f_i.z;
      COND_LS: pass_o = !f_i.c || f_i.z;
      COND_GE: pass_o = (f_i.n == f_i.v);
      COND_LT: pass_o = (f_i.n != f_i.v);
      COND_GT: pass_o = !f_i.z && (f_i.n == f_i.v);
      COND_LE: pass_o = f_i.z || (f_i.n != f_i.v);
      default: pass_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/addsub_cond_unit.sv
module addsub_cond_unit
  import addsub_cond_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              do_sub,
  input  logic              set_flags,
  input  logic [3:0]        cond_code,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic              cond_pass
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum_w;
  flags_t            flags_w;
  flags_t            flags_q;

  addsub_core #(.DATA_W(DATA_W)) u_core (
    .a_i    (op_a),
    .b_i    (op_b),
    .sub_i  (do_sub),
    .sum_o  (sum_w),
    .flags_o(flags_w)
  );

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= sum_w;
  end

  flag_store u_flags (
    .clk (clk),
    .rst (rst),
    .we_i(set_flags),
    .d_i (flags_w),
    .q_o (flags_q)
  );

  cond_eval u_cond (
    .f_i   (flags_q),
    .code_i(cond_code),
    .pass_o(cond_pass)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

  // R1
  result_math_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (result == ($past(do_sub) ? $past(op_a) - $past(op_b)
                                       : $past(op_a) + $past(op_b))));

  // R2
  neg_bit_chk: assert property (@(posedge clk) disable iff (rst)
    set_flags |=> (flag_n == result[MSB]));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    set_flags |=> (flag_z == (result == '0)));

  // R4
  no_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (set_flags && do_sub) |=> (flag_c == ($past(op_a) >= $past(op_b))));

  // R8
  always_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_code[3:1] == 3'b111) |-> cond_pass);

endmodule

// File: tb/addsub_cond_unit_tb.sv
`timescale 1ns/100ps
module addsub_cond_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] op_a, op_b;
  logic         do_sub, set_flags;
  logic [3:0]   cond_code;
  logic [W-1:0] result;
  logic         flag_n, flag_z, flag_c, flag_v, cond_pass;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  addsub_cond_unit #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .do_sub(do_sub),
    .set_flags(set_flags), .cond_code(cond_code), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .cond_pass(cond_pass)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_cond(input logic [3:0] c, input logic n, z, cy, v);
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  // one operation: drive at falling edge, sample just after the rising edge
  task automatic run_op(input logic [W-1:0] a, b, input logic sub, sf);
    @(negedge clk);
    op_a = a; op_b = b; do_sub = sub; set_flags = sf;
    @(posedge clk); #1;
    set_flags = 1'b0;
  endtask

  task automatic op_and_check(input logic [W-1:0] a, b, input logic sub);
    logic [W:0] wide;
    logic [W-1:0] r;
    logic en, ez, ec, ev;
    wide = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    r  = wide[W-1:0];
    en = r[W-1];
    ez = (r == 0);
    ec = sub ? (a >= b) : wide[W];
    ev = sub ? ((a[W-1] != b[W-1]) && (r[W-1] != a[W-1]))
             : ((a[W-1] == b[W-1]) && (r[W-1] != a[W-1]));
    run_op(a, b, sub, 1'b1);
    chk("R1 result", result, r);
    chk("R2 flag_n", flag_n, en);
    chk("R3 flag_z", flag_z, ez);
    chk("R4 flag_c", flag_c, ec);
    chk("R5 flag_v", flag_v, ev);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R7 result reset", result, 0);
    chk("R7 flags reset", {flag_n, flag_z, flag_c, flag_v}, 4'b0000);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_add;
    op_and_check(32'h0000_0000, 32'h0000_0000, 1'b0);
    op_and_check(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    op_and_check(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    op_and_check(32'h8000_0000, 32'h8000_0000, 1'b0);
    op_and_check(32'h0000_0005, 32'h0000_0007, 1'b0);
    op_and_check(32'hC000_0000, 32'h5000_0000, 1'b0);
  endtask

  task automatic t_sub;
    op_and_check(32'h0000_0005, 32'h0000_0005, 1'b1);
    op_and_check(32'h0000_0003, 32'h0000_0005, 1'b1);
    op_and_check(32'h8000_0000, 32'h0000_0001, 1'b1);
    op_and_check(32'h0000_0000, 32'h8000_0000, 1'b1);
    op_and_check(32'h1234_5678, 32'h0000_1000, 1'b1);
  endtask

  task automatic t_hold;
    op_and_check(32'h7FFF_FFFF, 32'h0000_0001, 1'b0); // N=1 Z=0 C=0 V=1
    run_op(32'h0000_0004, 32'h0000_0004, 1'b1, 1'b0);
    chk("R6 result moves", result, 32'h0);
    chk("R6 flags held", {flag_n, flag_z, flag_c, flag_v}, 4'b1001);
    run_op(32'hFFFF_FFFF, 32'h0000_0002, 1'b0, 1'b0);
    chk("R6 result moves 2", result, 32'h1);
    chk("R6 flags held 2", {flag_n, flag_z, flag_c, flag_v}, 4'b1001);
  endtask

  task automatic sweep_codes(input string tag);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cond_code = c[3:0];
      #1;
      chk({"R8 R9 ", tag}, cond_pass, exp_cond(c[3:0], flag_n, flag_z, flag_c, flag_v));
    end
  endtask

  task automatic t_cond;
    op_and_check(32'h0000_0005, 32'h0000_0005, 1'b1); // Z=1 C=1
    sweep_codes("zero");
    op_and_check(32'h0000_0003, 32'h0000_0005, 1'b1); // N=1 C=0
    sweep_codes("neg");
    op_and_check(32'h8000_0000, 32'h0000_0001, 1'b1); // V=1 C=1
    sweep_codes("ovf");
    op_and_check(32'h0000_0009, 32'h0000_0002, 1'b1); // C=1 only
    sweep_codes("pos");
  endtask

  task automatic t_table;
    logic [3:0] codes [8] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd9};
    logic       want  [8] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    op_and_check(32'h0000_0003, 32'h0000_0005, 1'b1); // N=1 Z=0 C=0
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cond_code = codes[i];
      #1;
      chk("R10 table", cond_pass, want[i]);
    end
  endtask

  initial begin
    rst = 1'b1; op_a = '0; op_b = '0; do_sub = 1'b0; set_flags = 1'b0;
    cond_code = 4'd14;
    repeat (2) @(posedge clk);
    t_reset();
    t_add();
    t_sub();
    t_hold();
    t_cond();
    t_table();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule